// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits on the processor side of an 8-bit address/data bus that carries a 20-bit address. The low address byte shares its lines with data. The middle address byte has lines of its own. The top four address bits share their lines with cycle status. A requester presents one transfer at a time: a memory read or write, a code fetch, an I/O read or write, an interrupt acknowledge or a halt. With it come an address, write data, a segment tag and a width flag. The sequencer runs the transfer as a bus cycle (T1, T2, T3, any wait states, then T4) and drives the address, data, strobes and decodable status code for each phase. It returns read data when the cycle ends and marks that moment with a one-clock completion pulse.

Every T-state takes two clocks of `clk_i`: a first (high) half and a second (low) half. This lets strobes that start or end in the middle of a T-state be produced on clock edges. A 16-bit request runs as two byte cycles, one straight after the other. A bus-hold request from another master is granted in the middle of a T4 or an idle state. While the hold lasts, every output that can float is reported through an output-enable pin and parked at its inactive level.

The requester keeps `req_valid_i` and the request fields stable until `done_o` and drops them at once after it. A new cycle starts only from an idle state, so separate requests always have at least one idle T-state between them.

Top module: `mux_bus_seq`

## Requirements
- R1: Each cycle runs T1, T2, T3, then zero or more Tw, then T4. Every T-state lasts two clocks. `ready_i` is sampled at the last edge of T3 or of each Tw: high goes to T4, low adds one more Tw. `done_o` is high during the second half of the final T4 only.
- R2: `ad_o` carries address bits 7:0 throughout T1. The exception is interrupt acknowledge, where the lines float. For writes, the write byte is on `ad_o` from T2 through T4. For reads the lines float from T2 onward. A floating `ad_o` reads 0 with `ad_oe_o` low. `a_mid_o` holds address bits 15:8 from T1 through T4 and is 0 outside a cycle. `a_mid_oe_o` is low during interrupt-acknowledge cycles and during hold.
- R3: `ale_o` is high in the second half of T1 of every cycle and at no other time.
- R4: `rd_no` goes low for code fetch, memory read and I/O read. `wr_no` goes low for memory write and I/O write. `inta_no` goes low for interrupt acknowledge. Each is low in both halves of T2, T3 and every Tw, and high at all other times.
- R5: `den_no` goes low from the middle of T2 to the middle of T4 for reads and interrupt acknowledge. For writes it goes low from the start of T2 to the middle of T4. It stays high in halt cycles.
- R6: The status code {`iom_o`,`dtr_o`,`ss0_o`}, which is also the request kind encoding, is 000 code fetch, 001 memory read, 010 memory write, 011 passive, 100 interrupt acknowledge, 101 I/O read, 110 I/O write, 111 halt. The code of the current cycle is shown from T1 through the last Tw. In T4 the code of a second byte cycle that follows is shown, or 011 if none follows. In an idle state the code of a waiting request is shown, or 011 if there is none.
- R7: In T1, `a_hi_o` carries address bits 19:16, or 0 for the codes 100 to 111. From T2 through T4 it carries status: bit 3 is 0, bit 2 follows `ie_flag_i` live, and bits 1:0 are the request's segment tag. The tag is 00 extra, 01 stack, 10 code or none, 11 data. Outside a cycle the lines read 0.
- R8: `hold_i` is sampled at the mid-point edge of T4 or an idle state. If it is high, `hlda_o` rises for the second half, and from then on no new cycle starts. While `hlda_o` is high, `ctl_oe_o` and all output enables are low, the strobes and `den_no` are 1, and the status code is 111. `hold_i` seen low at a mid-point edge of the hold state drops `hlda_o`. The next T-state is then idle.
- R9: In cycles of kind 000, 001, 101 and 100, `ad_i` is captured when `ready_i` is sampled high. The byte lands in `rdata_o[7:0]`, or in `rdata_o[15:8]` for the second byte. `rdata_o` clears when a request starts.
- R10: When `req_wide_i` is set, a second byte cycle at address+1 (wrapping at 20 bits) follows T4 with no idle state between. It uses the high write byte. `done_o` fires only at the end of the second cycle.
- R11: A request of kind 011 never starts a cycle.
- R12: After reset the bus is idle, with no hold granted. The strobes and `den_no` are 1, `ale_o` is 0, the status code is 011, and `ad_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, two per T-state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_kind_i | input | 3 | Request kind, status code encoding |
| req_wide_i | input | 1 | 16-bit operand, two byte cycles |
| req_addr_i | input | 20 | Byte address |
| req_wdata_i | input | 16 | Write data, low byte first |
| req_seg_i | input | 2 | Segment tag for status |
| ie_flag_i | input | 1 | Interrupt-enable flag for status |
| ready_i | input | 1 | Device ready |
| hold_i | input | 1 | Bus-hold request |
| ad_i | input | 8 | Read data from shared lines |
| ad_o | output | 8 | Shared address/data lines |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| a_mid_o | output | 8 | Address bits 15:8 |
| a_mid_oe_o | output | 1 | Drive enable for a_mid_o |
| a_hi_o | output | 4 | Address 19:16 or status |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| den_no | output | 1 | Data transceiver enable, active low |
| dtr_o | output | 1 | Status code bit 1, transmit/receive |
| iom_o | output | 1 | Status code bit 2, I/O or memory |
| ss0_o | output | 1 | Status code bit 0 |
| ctl_oe_o | output | 1 | Drive enable for control and upper lines |
| hlda_o | output | 1 | Hold acknowledge |
| done_o | output | 1 | Final T4 second half |
| rdata_o | output | 16 | Read data |

## Verification
The bench runs every request kind at least once with `ready_i` held high. This separates the per-kind strobe, status and data-enable decoding from any effect of wait states. Code fetches and reads then run with `ready_i` following a pseudo-random bit, which exercises variable runs of Tw and shows that sampling and data capture happen on the last wait edge only. Wide reads and writes at the top of the address space test the second-byte address wrap and the lane ordering. Hold pulses, overlapped with idle time and with wide transfers, show where the grant may occur and what floats. A kind-011 request shows that it never starts a cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    TS_I = 3'd0, TS_1 = 3'd1, TS_2 = 3'd2, TS_3 = 3'd3,
    TS_W = 3'd4, TS_4 = 3'd5, TS_H = 3'd6
  } tstate_e;

  localparam logic [2:0] K_CODE = 3'b000;
  localparam logic [2:0] K_MRD  = 3'b001;
  localparam logic [2:0] K_MWR  = 3'b010;
  localparam logic [2:0] K_PASS = 3'b011;
  localparam logic [2:0] K_INTA = 3'b100;
  localparam logic [2:0] K_IORD = 3'b101;
  localparam logic [2:0] K_IOWR = 3'b110;
  localparam logic [2:0] K_HALT = 3'b111;

  function automatic logic k_write(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic k_rdstb(input logic [2:0] k);
    return (k == K_CODE) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic k_takes(input logic [2:0] k);
    return k_rdstb(k) || (k == K_INTA);
  endfunction
endpackage

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
  import mbs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    more_i,
  input  logic    ready_i,
  input  logic    hold_i,
  output tstate_e st_o,
  output logic    ph_o,
  output logic    hlda_o,
  output logic    load_o,
  output logic    adv_o
);
  tstate_e st_q, st_d;
  logic    ph_q, hlda_q, hlda_d;

  assign load_o = ph_q && (st_q == TS_I) && !hlda_q && start_i;
  assign adv_o  = ph_q && (st_q == TS_4) && !hlda_q && more_i;

  always_comb begin
    st_d = st_q;
    if (ph_q) begin
      case (st_q)
        TS_I:       st_d = hlda_q ? TS_H : (start_i ? TS_1 : TS_I);
        TS_1:       st_d = TS_2;
        TS_2:       st_d = TS_3;
        TS_3, TS_W: st_d = ready_i ? TS_4 : TS_W;
        TS_4:       st_d = hlda_q ? TS_H : (more_i ? TS_1 : TS_I);
        TS_H:       st_d = hlda_q ? TS_H : TS_I;
        default:    st_d = TS_I;
      endcase
    end
  end

  // grant and release only at the mid-point edge of a T-state
  always_comb begin
    hlda_d = hlda_q;
    if (!ph_q) begin
      if (!hlda_q && hold_i && (st_q == TS_4 || st_q == TS_I)) hlda_d = 1'b1;
      else if (hlda_q && !hold_i && st_q == TS_H)              hlda_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TS_I;
      ph_q   <= 1'b0;
      hlda_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= !ph_q;
      hlda_q <= hlda_d;
    end
  end

  assign st_o   = st_q;
  assign ph_o   = ph_q;
  assign hlda_o = hlda_q;
endmodule

// File: rtl/mbs_ctx.sv
module mbs_ctx
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            adv_i,
  input  logic            cap_i,
  input  logic [2:0]      kind_i,
  input  logic            wide_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [2*BW-1:0] wdata_i,
  input  logic [1:0]      seg_i,
  input  logic [BW-1:0]   din_i,
  output logic [2:0]      kind_o,
  output logic [AW-1:0]   addr_o,
  output logic [BW-1:0]   wbyte_o,
  output logic [1:0]      seg_o,
  output logic            more_o,
  output logic            last_o,
  output logic [2*BW-1:0] rdata_o
);
  localparam int LANES = 2;

  logic [2:0]      kind_q;
  logic [AW-1:0]   base_q;
  logic [2*BW-1:0] wd_q;
  logic [1:0]      seg_q;
  logic            wide_q, idx_q;
  logic [BW-1:0]   lane_q [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_PASS;
      base_q <= '0;
      wd_q   <= '0;
      seg_q  <= '0;
      wide_q <= 1'b0;
      idx_q  <= 1'b0;
    end else if (load_i) begin
      kind_q <= kind_i;
      base_q <= addr_i;
      wd_q   <= wdata_i;
      seg_q  <= seg_i;
      wide_q <= wide_i;
      idx_q  <= 1'b0;
    end else if (adv_i) begin
      idx_q  <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          lane_q[g] <= '0;
      else if (load_i)                      lane_q[g] <= '0;
      else if (cap_i && (idx_q == g[0]))    lane_q[g] <= din_i;
    end
    assign rdata_o[g*BW +: BW] = lane_q[g];
  end

  assign kind_o  = kind_q;
  assign addr_o  = base_q + AW'(idx_q);
  assign wbyte_o = idx_q ? wd_q[2*BW-1:BW] : wd_q[BW-1:0];
  assign seg_o   = seg_q;
  assign more_o  = wide_q && !idx_q;
  assign last_o  = !more_o;
endmodule

// File: rtl/mbs_out_dec.sv
module mbs_out_dec
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input  tstate_e          st_i,
  input  logic             ph_i,
  input  logic             hlda_i,
  input  logic [2:0]       kind_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BW-1:0]    wbyte_i,
  input  logic [1:0]       seg_i,
  input  logic             ie_i,
  input  logic             more_i,
  input  logic             last_i,
  input  logic             req_ok_i,
  input  logic [2:0]       req_kind_i,
  output logic [BW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [BW-1:0]    mid_o,
  output logic             mid_oe_o,
  output logic [AW-2*BW-1:0] hi_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             inta_no,
  output logic             den_no,
  output logic [2:0]       code_o,
  output logic             done_o
);
  localparam int HI_W = AW - 2*BW;

  logic in_cyc, strb, tail, is_inta, den_act, ad_en;
  logic [BW-1:0] ad_val;

  always_comb begin
    in_cyc  = st_i inside {TS_1, TS_2, TS_3, TS_W, TS_4};
    strb    = st_i inside {TS_2, TS_3, TS_W};
    tail    = strb || (st_i == TS_4 && !ph_i);
    is_inta = (kind_i == K_INTA);

    ale_o   = (st_i == TS_1) && ph_i;
    rd_no   = !(strb && k_rdstb(kind_i));
    wr_no   = !(strb && k_write(kind_i));
    inta_no = !(strb && is_inta);

    // reads open the transceiver half a state later than writes
    if (k_write(kind_i)) den_act = tail;
    else                 den_act = k_takes(kind_i) && tail && !(st_i == TS_2 && !ph_i);
    den_no = !den_act;

    ad_en  = 1'b0;
    ad_val = '0;
    if (st_i == TS_1 && !is_inta) begin
      ad_en  = 1'b1;
      ad_val = addr_i[BW-1:0];
    end else if (st_i inside {TS_2, TS_3, TS_W, TS_4} && k_write(kind_i)) begin
      ad_en  = 1'b1;
      ad_val = wbyte_i;
    end
    if (hlda_i) ad_en = 1'b0;
    ad_oe_o = ad_en;
    ad_o    = ad_en ? ad_val : '0;

    mid_o    = in_cyc ? addr_i[2*BW-1:BW] : '0;
    mid_oe_o = !hlda_i && !(in_cyc && is_inta);

    if (st_i == TS_1)  hi_o = kind_i[2] ? '0 : addr_i[AW-1:2*BW];
    else if (in_cyc)   hi_o = {{(HI_W-3){1'b0}}, ie_i, seg_i};
    else               hi_o = '0;

    if (hlda_i)                                  code_o = 3'b111;
    else if (st_i inside {TS_1, TS_2, TS_3, TS_W}) code_o = kind_i;
    else if (st_i == TS_4)                       code_o = more_i ? kind_i : K_PASS;
    else if (st_i == TS_I)                       code_o = req_ok_i ? req_kind_i : K_PASS;
    else                                         code_o = K_PASS;

    done_o = (st_i == TS_4) && ph_i && last_i;
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic              req_wide_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [2*BW-1:0]   req_wdata_i,
  input  logic [1:0]        req_seg_i,
  input  logic              ie_flag_i,
  input  logic              ready_i,
  input  logic              hold_i,
  input  logic [BW-1:0]     ad_i,
  output logic [BW-1:0]     ad_o,
  output logic              ad_oe_o,
  output logic [BW-1:0]     a_mid_o,
  output logic              a_mid_oe_o,
  output logic [AW-2*BW-1:0] a_hi_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              inta_no,
  output logic              den_no,
  output logic              dtr_o,
  output logic              iom_o,
  output logic              ss0_o,
  output logic              ctl_oe_o,
  output logic              hlda_o,
  output logic              done_o,
  output logic [2*BW-1:0]   rdata_o
);
  tstate_e       st;
  logic          ph, hlda, load, adv, more, last, cap, req_ok;
  logic [2:0]    kind, code;
  logic [AW-1:0] addr;
  logic [BW-1:0] wbyte;
  logic [1:0]    seg;

  assign req_ok = req_valid_i && (req_kind_i != K_PASS);
  assign cap    = ph && (st == TS_3 || st == TS_W) && ready_i && k_takes(kind);

  mbs_phase_fsm i_fsm (
    .clk_i, .rst_ni,
    .start_i (req_ok),
    .more_i  (more),
    .ready_i,
    .hold_i,
    .st_o    (st),
    .ph_o    (ph),
    .hlda_o  (hlda),
    .load_o  (load),
    .adv_o   (adv)
  );

  mbs_ctx #(.AW(AW), .BW(BW)) i_ctx (
    .clk_i, .rst_ni,
    .load_i  (load),
    .adv_i   (adv),
    .cap_i   (cap),
    .kind_i  (req_kind_i),
    .wide_i  (req_wide_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .seg_i   (req_seg_i),
    .din_i   (ad_i),
    .kind_o  (kind),
    .addr_o  (addr),
    .wbyte_o (wbyte),
    .seg_o   (seg),
    .more_o  (more),
    .last_o  (last),
    .rdata_o
  );

  mbs_out_dec #(.AW(AW), .BW(BW)) i_dec (
    .st_i       (st),
    .ph_i       (ph),
    .hlda_i     (hlda),
    .kind_i     (kind),
    .addr_i     (addr),
    .wbyte_i    (wbyte),
    .seg_i      (seg),
    .ie_i       (ie_flag_i),
    .more_i     (more),
    .last_i     (last),
    .req_ok_i   (req_ok),
    .req_kind_i (req_kind_i),
    .ad_o, .ad_oe_o,
    .mid_o      (a_mid_o),
    .mid_oe_o   (a_mid_oe_o),
    .hi_o       (a_hi_o),
    .ale_o, .rd_no, .wr_no, .inta_no, .den_no,
    .code_o     (code),
    .done_o
  );

  assign iom_o    = code[2];
  assign dtr_o    = code[1];
  assign ss0_o    = code[0];
  assign ctl_oe_o = !hlda;
  assign hlda_o   = hlda;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic rd_no,
  input logic wr_no,
  input logic inta_no,
  input logic den_no,
  input logic ad_oe_o,
  input logic hlda_o,
  input logic iom_o,
  input logic dtr_o,
  input logic ss0_o,
  input logic done_o
);
  AST_ALE_SINGLE_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R3

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~rd_no, ~wr_no, ~inta_no}) <= 1); // R4

  AST_READ_FLOATS_AD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !inta_no) |-> !ad_oe_o); // R2

  AST_DEN_OFF_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> den_no); // R5

  AST_STROBES_OFF_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && inta_no)); // R1

  AST_HOLD_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (rd_no && wr_no && den_no && !ad_oe_o && iom_o && dtr_o && ss0_o)); // R8

  AST_NO_ALE_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !hlda_o); // R8
endmodule

bind mux_bus_seq mbs_checker i_mbs_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ale_o   (ale_o),
  .rd_no   (rd_no),
  .wr_no   (wr_no),
  .inta_no (inta_no),
  .den_no  (den_no),
  .ad_oe_o (ad_oe_o),
  .hlda_o  (hlda_o),
  .iom_o   (iom_o),
  .dtr_o   (dtr_o),
  .ss0_o   (ss0_o),
  .done_o  (done_o)
);

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_wide_i = 1'b0, ie_flag_i = 1'b0;
  logic [2:0]  req_kind_i = 3'b011;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_seg_i = '0;
  logic        ready_i = 1'b1, hold_i = 1'b0;
  logic [7:0]  ad_i;
  logic [7:0]  ad_o, a_mid_o;
  logic        ad_oe_o, a_mid_oe_o, ale_o, rd_no, wr_no, inta_no, den_no;
  logic        dtr_o, iom_o, ss0_o, ctl_oe_o, hlda_o, done_o;
  logic [3:0]  a_hi_o;
  logic [15:0] rdata_o;

  always #5 clk_i = ~clk_i;

  mux_bus_seq i_mux_bus_seq (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit wait_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  assign ad_i = lfsr[7:0];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // reference model: 0 TI,1 T1,2 T2,3 T3,4 TW,5 T4,6 TH
  int m_st, m_ph, m_hl, m_idx, m_wide, m_seg, m_kind;
  int m_addr, m_wd, m_rd;

  function automatic bit kw(int k); return k == 2 || k == 6; endfunction
  function automatic bit kr(int k); return k == 0 || k == 1 || k == 5; endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_ph = 0; m_hl = 0; m_idx = 0; m_wide = 0; m_seg = 0;
      m_kind = 3; m_addr = 0; m_wd = 0; m_rd = 0;
    end else begin
      int ost, ohl;
      ost = m_st; ohl = m_hl;
      if (m_ph == 1 && (ost == 3 || ost == 4) && ready_i && (kr(m_kind) || m_kind == 4)) begin
        if (m_idx == 1) m_rd = (m_rd & 'h00FF) | (int'(ad_i) << 8);
        else            m_rd = (m_rd & 'hFF00) | int'(ad_i);
      end
      if (m_ph == 1) begin
        case (ost)
          0: if (ohl) m_st = 6;
             else if (req_valid_i && req_kind_i != 3'b011) begin
               m_st = 1; m_kind = req_kind_i; m_addr = req_addr_i; m_wd = req_wdata_i;
               m_seg = req_seg_i; m_wide = req_wide_i; m_idx = 0; m_rd = 0;
             end
          1: m_st = 2;
          2: m_st = 3;
          3, 4: m_st = ready_i ? 5 : 4;
          5: if (ohl) m_st = 6;
             else if (m_wide == 1 && m_idx == 0) begin m_st = 1; m_idx = 1; end
             else m_st = 0;
          default: m_st = ohl ? 6 : 0;
        endcase
      end else begin
        if (!ohl && hold_i && (ost == 5 || ost == 0)) m_hl = 1;
        else if (ohl && !hold_i && ost == 6) m_hl = 0;
      end
      m_ph = 1 - m_ph;
    end
  end

  // compare every clock, away from both edges
  always @(negedge clk_i) begin
    #2;
    if (rst_ni) begin
      int a, code;
      bit incyc, strb, tail, den, aoe;
      int av, hi, mid;
      string ta;
      a = (m_addr + m_idx) & 'hFFFFF;
      incyc = m_st >= 1 && m_st <= 5;
      strb = m_st >= 2 && m_st <= 4;
      tail = strb || (m_st == 5 && m_ph == 0);
      if (kw(m_kind)) den = tail;
      else if (kr(m_kind) || m_kind == 4) den = tail && !(m_st == 2 && m_ph == 0);
      else den = 0;
      aoe = 0; av = 0;
      if (m_st == 1 && m_kind != 4) begin aoe = 1; av = a & 'hFF; end
      else if (m_st >= 2 && m_st <= 5 && kw(m_kind)) begin
        aoe = 1; av = m_idx ? (m_wd >> 8) & 'hFF : m_wd & 'hFF;
      end
      if (m_hl) aoe = 0;
      if (!aoe) av = 0;
      mid = incyc ? (a >> 8) & 'hFF : 0;
      if (m_st == 1) hi = (m_kind >= 4) ? 0 : (a >> 16) & 'hF;
      else if (incyc) hi = (int'(ie_flag_i) << 2) | m_seg;
      else hi = 0;
      if (m_hl) code = 7;
      else if (m_st >= 1 && m_st <= 4) code = m_kind;
      else if (m_st == 5) code = (m_wide == 1 && m_idx == 0) ? m_kind : 3;
      else if (m_st == 0) code = (req_valid_i && req_kind_i != 3'b011) ? int'(req_kind_i) : 3;
      else code = 3;
      ta = (m_idx == 1) ? "R10" : "R2";

      chk(ale_o == (m_st == 1 && m_ph == 1), "R3", "ale_o", ale_o, m_st == 1 && m_ph == 1);
      chk(rd_no == !(strb && kr(m_kind)), "R4", "rd_no", rd_no, !(strb && kr(m_kind)));
      chk(wr_no == !(strb && kw(m_kind)), "R4", "wr_no", wr_no, !(strb && kw(m_kind)));
      chk(inta_no == !(strb && m_kind == 4), "R4", "inta_no", inta_no, !(strb && m_kind == 4));
      chk(den_no == !den, "R5", "den_no", den_no, !den);
      chk(ad_oe_o == aoe && int'(ad_o) == av, ta, "ad_o/oe", {ad_oe_o, ad_o}, {aoe, av[7:0]});
      chk(int'(a_mid_o) == mid, ta, "a_mid_o", a_mid_o, mid);
      chk(a_mid_oe_o == (!m_hl && !(incyc && m_kind == 4)), "R2", "a_mid_oe_o",
          a_mid_oe_o, !m_hl && !(incyc && m_kind == 4));
      chk(int'(a_hi_o) == hi, "R7", "a_hi_o", a_hi_o, hi);
      chk(int'({iom_o, dtr_o, ss0_o}) == code, "R6", "status", {iom_o, dtr_o, ss0_o}, code);
      chk(hlda_o == m_hl[0] && ctl_oe_o == !m_hl[0], "R8", "hlda/ctl_oe",
          {hlda_o, ctl_oe_o}, {m_hl[0], !m_hl[0]});
      chk(done_o == (m_st == 5 && m_ph == 1 && (m_wide == 0 || m_idx == 1)), "R1", "done_o",
          done_o, m_st == 5 && m_ph == 1 && (m_wide == 0 || m_idx == 1));
      chk(int'(rdata_o) == m_rd, "R9", "rdata_o", rdata_o, m_rd);
    end
  end

  always @(negedge clk_i) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (wait_mode) ready_i <= lfsr[3] | lfsr[9];
    else           ready_i <= 1'b1;
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic do_req(input logic [2:0] k, input bit w, input logic [19:0] ad,
                        input logic [15:0] wd, input logic [1:0] sg);
    @(negedge clk_i);
    req_valid_i = 1; req_kind_i = k; req_wide_i = w;
    req_addr_i = ad; req_wdata_i = wd; req_seg_i = sg;
    do begin @(negedge clk_i); #1; end while (!done_o);
    req_valid_i = 0; req_kind_i = 3'b011;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #3;
    // R12 reset state
    chk(ale_o == 0 && rd_no && wr_no && inta_no && den_no, "R12", "strobes",
        {ale_o, rd_no, wr_no, inta_no, den_no}, 5'b01111);
    chk({iom_o, dtr_o, ss0_o} == 3'b011 && !hlda_o && !ad_oe_o, "R12", "status/hold",
        {iom_o, dtr_o, ss0_o, hlda_o, ad_oe_o}, 5'b01100);

    do_req(3'b001, 0, 20'hA5C3E, 16'h0000, 2'b11);   // memory read
    ie_flag_i = 1;
    do_req(3'b010, 0, 20'h12345, 16'h005A, 2'b01);   // memory write
    do_req(3'b101, 0, 20'hF0081, 16'h0000, 2'b10);   // I/O read, upper low in T1
    do_req(3'b110, 0, 20'h00F3C, 16'h00C7, 2'b00);   // I/O write
    do_req(3'b100, 0, 20'h00000, 16'h0000, 2'b10);   // interrupt acknowledge
    do_req(3'b111, 0, 20'h3FFF0, 16'h0000, 2'b10);   // halt
    do_req(3'b000, 0, 20'hFFFF0, 16'h0000, 2'b10);   // code fetch
    wait_mode = 1;                                   // R1 wait states
    for (int i = 0; i < 6; i++) begin
      do_req(3'b000, 0, 20'h01000 + 20'(i), 16'h0, 2'b10);
      ie_flag_i = ~ie_flag_i;
    end
    do_req(3'b001, 1, 20'hFFFFF, 16'h0, 2'b11);      // R10 wide read wraps
    chk(rdata_o == 16'(m_rd), "R10", "wide rdata", rdata_o, m_rd);
    do_req(3'b010, 1, 20'h7FFFF, 16'hBEEF, 2'b00);   // wide write
    wait_mode = 0;
    // R8 hold in idle
    @(negedge clk_i); hold_i = 1;
    repeat (6) @(negedge clk_i);
    #3 chk(hlda_o && !ctl_oe_o, "R8", "hold granted in idle", {hlda_o, ctl_oe_o}, 2'b10);
    hold_i = 0;
    repeat (6) @(negedge clk_i);
    #3 chk(!hlda_o, "R8", "hold released", hlda_o, 0);
    // R8 hold overlapping wide transfers
    for (int d = 3; d < 12; d += 2) begin
      fork
        do_req(3'b101, 1, 20'h0ABCD, 16'h0, 2'b01);
        begin repeat (d) @(negedge clk_i); hold_i = 1;
              repeat (5) @(negedge clk_i); hold_i = 0; end
      join
    end
    // R11 passive kind never starts
    begin
      int seen = 0;
      @(negedge clk_i); req_valid_i = 1; req_kind_i = 3'b011;
      repeat (20) begin @(negedge clk_i); #3; if (ale_o) seen++; end
      chk(seen == 0, "R11", "ale count for kind 011", seen, 0);
      req_valid_i = 0;
    end
    repeat (4) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule